// File: doc/BRIEF.md
# Hibernate Wakeup Filter and Reset Sequencer

This block gates main power for a chip that can sleep. Software writes a command that puts the block into hibernate, and the main-power-enable output drops. The chip then waits for an external wakeup pin. That pin first passes through a two-flop synchronizer. It must then stay asserted for a programmable number of slow-clock ticks before the wakeup is accepted. A shorter pulse is treated as noise: the filter count clears and the block stays asleep.

Once a wakeup is accepted, power returns at once, but an active-low system reset stays asserted for a programmable number of ticks before it is released. Both durations are written as register fields whose lowest five bits are ignored, so each duration moves in steps of 32 ticks. At a 32 kHz tick the filter spans about two seconds and the reset hold about 125 ms.

Top module: `hib_wake_ctrl`

## Requirements
- R1: After reset, `pwr_en` is 1 and `sys_rst_n` is 1.
- R2: A write with `wr_sel`=0 and `wr_data[0]`=1 while running drives `pwr_en` to 0 from the next clock edge. A write with `wr_sel`=0 and `wr_data[0]`=0 has no effect.
- R3: `wake_pin` passes through two synchronizing flip-flops before the filter sees it.
- R4: The filter threshold T is `wr_data[15:5]`*32, written with `wr_sel`=1. If `wake_pin` is sampled high at T+2 consecutive edges during hibernate, `pwr_en` rises at the (T+4)th edge after it was first driven high.
- R5: If `wake_pin` is high for only T+1 edges, the block stays in hibernate. The filter count clears, so a later attempt needs the full duration again.
- R6: Bits 4:0 of the filter value are ignored.
- R7: The hold value H is `wr_data[11:5]`*32, written with `wr_sel`=2, with bits 4:0 ignored. `sys_rst_n` is 0 for exactly H+1 cycles, starting on the edge where `pwr_en` rises.
- R8: `wake_pin` has no effect while running. A hibernate command during the reset hold is ignored.
- R9: `pwr_en` falls only after a hibernate command and only while `sys_rst_n` is 1. `sys_rst_n` is 0 only while `pwr_en` is 1. Power returns only after the synchronized pin was high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 command, 1 filter, 2 hold |
| wr_data | input | 16 | Write data |
| wake_pin | input | 1 | Asynchronous wakeup request, active high |
| pwr_en | output | 1 | Main power enable |
| sys_rst_n | output | 1 | Active-low system reset |

## Verification
The hardest case to reach is the edge of the filter: a pin pulse one tick shorter than the acceptance length, followed by a retry. Only the retry shows whether the count really cleared. The stimulus drives the pin for exactly T+1 and then exactly T+2 sampled edges. It then re-asserts the pin after a brief low gap and expects the full latency again. A hibernate command issued in the middle of the reset hold checks that the command is ignored outside the running state.

// File: rtl/hib_wake_pkg.sv
package hib_wake_pkg;
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_HIB  = 2'd1,
        ST_FILT = 2'd2,
        ST_HOLD = 2'd3
    } hib_state_e;

    localparam logic [1:0] SEL_CMD  = 2'd0;
    localparam logic [1:0] SEL_FILT = 2'd1;
    localparam logic [1:0] SEL_HOLD = 2'd2;

    localparam int GRAN_BITS = 5;
endpackage

// File: rtl/hib_sync.sv
module hib_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign sync_out = sh_q[STAGES-1];
endmodule

// File: rtl/hib_cfg.sv
module hib_cfg
    import hib_wake_pkg::*;
#(
    parameter int                DATA_W    = 16,
    parameter int                FILT_W    = 16,
    parameter int                HOLD_W    = 12,
    parameter logic [FILT_W-1:0] FILT_INIT = 16'h07A0,
    parameter logic [HOLD_W-1:0] HOLD_INIT = 12'hCC0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              hib_req,
    output logic [FILT_W-1:0] filt_ticks,
    output logic [HOLD_W-1:0] hold_ticks
);
    localparam logic [FILT_W-1:0] FILT_MASK = ~FILT_W'((1 << GRAN_BITS) - 1);
    localparam logic [HOLD_W-1:0] HOLD_MASK = ~HOLD_W'((1 << GRAN_BITS) - 1);

    typedef struct packed {
        logic [FILT_W-1:0] filt;
        logic [HOLD_W-1:0] hold;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d   = cfg_q;
        hib_req = 1'b0;
        if (wr_en) begin
            case (wr_sel)
                SEL_CMD:  hib_req    = wr_data[0];
                SEL_FILT: cfg_d.filt = wr_data[FILT_W-1:0] & FILT_MASK;
                SEL_HOLD: cfg_d.hold = wr_data[HOLD_W-1:0] & HOLD_MASK;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '{filt: FILT_INIT & FILT_MASK, hold: HOLD_INIT & HOLD_MASK};
        else        cfg_q <= cfg_d;
    end

    assign filt_ticks = cfg_q.filt;
    assign hold_ticks = cfg_q.hold;
endmodule

// File: rtl/hib_fsm.sv
module hib_fsm
    import hib_wake_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hib_req,
    input  logic             wake_s,
    input  logic [CNT_W-1:0] filt_lim,
    input  logic [CNT_W-1:0] hold_lim,
    output logic             pwr_en,
    output logic             sys_rst_n
);
    typedef struct packed {
        hib_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic             pwr;
        logic             rstn;
    } fsm_t;

    fsm_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            ST_RUN: begin
                if (hib_req) begin
                    s_d.st  = ST_HIB;
                    s_d.cnt = '0;
                end
            end
            ST_HIB: begin
                if (wake_s) begin
                    s_d.st  = ST_FILT;
                    s_d.cnt = '0;
                end
            end
            ST_FILT: begin
                if (!wake_s) begin
                    s_d.st  = ST_HIB;
                    s_d.cnt = '0;
                end else if (s_q.cnt >= filt_lim) begin
                    s_d.st  = ST_HOLD;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt + CNT_W'(1);
                end
            end
            ST_HOLD: begin
                if (s_q.cnt >= hold_lim) begin
                    s_d.st  = ST_RUN;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt + CNT_W'(1);
                end
            end
            default: begin
                s_d.st  = ST_RUN;
                s_d.cnt = '0;
            end
        endcase
        s_d.pwr  = (s_d.st == ST_RUN) || (s_d.st == ST_HOLD);
        s_d.rstn = (s_d.st != ST_HOLD);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_RUN, cnt: '0, pwr: 1'b1, rstn: 1'b1};
        else        s_q <= s_d;
    end

    assign pwr_en    = s_q.pwr;
    assign sys_rst_n = s_q.rstn;
endmodule

// File: rtl/hib_wake_ctrl.sv
module hib_wake_ctrl
    import hib_wake_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int FILT_W      = 16,
    parameter int HOLD_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wake_pin,
    output logic              pwr_en,
    output logic              sys_rst_n
);
    localparam int CNT_W = (FILT_W > HOLD_W) ? FILT_W : HOLD_W;

    logic              wake_s;
    logic              hib_req;
    logic [FILT_W-1:0] filt_ticks;
    logic [HOLD_W-1:0] hold_ticks;

    hib_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (wake_pin),
        .sync_out (wake_s)
    );

    hib_cfg #(.DATA_W(DATA_W), .FILT_W(FILT_W), .HOLD_W(HOLD_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .hib_req    (hib_req),
        .filt_ticks (filt_ticks),
        .hold_ticks (hold_ticks)
    );

    hib_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .hib_req   (hib_req),
        .wake_s    (wake_s),
        .filt_lim  (CNT_W'(filt_ticks)),
        .hold_lim  (CNT_W'(hold_ticks)),
        .pwr_en    (pwr_en),
        .sys_rst_n (sys_rst_n)
    );
endmodule

// File: rtl/hib_wake_chk.sv
module hib_wake_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [1:0] wr_sel,
    input logic       cmd_bit,
    input logic       wake_s,
    input logic       pwr_en,
    input logic       sys_rst_n
);
    AST_PWR_FALL_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_en) |-> $past(wr_en && wr_sel == 2'd0 && cmd_bit)); // R2

    AST_PWR_FALL_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_en) |-> $past(sys_rst_n)); // R9

    AST_WAKE_NEEDS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_en) |-> $past(wake_s)); // R4

    AST_RESET_ON_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_en) |-> !sys_rst_n); // R7

    AST_RESET_ONLY_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_rst_n |-> pwr_en); // R9

    AST_RELEASE_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_n) |-> pwr_en && $past(pwr_en)); // R7
endmodule

bind hib_wake_ctrl hib_wake_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .cmd_bit   (wr_data[0]),
    .wake_s    (wake_s),
    .pwr_en    (pwr_en),
    .sys_rst_n (sys_rst_n)
);

// File: tb/tb_hib_wake_ctrl.sv
module tb_hib_wake_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        wake_pin = 1'b0;
    logic        pwr_en, sys_rst_n;

    hib_wake_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .wake_pin(wake_pin),
        .pwr_en(pwr_en), .sys_rst_n(sys_rst_n)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    at;
        logic  pwr;
        logic  rstn;
        string req;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    task automatic expect_at(int at, logic p, logic r, string req);
        exp_t e;
        e.at = at; e.pwr = p; e.rstn = r; e.req = req;
        q.push_back(e);
    endtask

    task automatic expect_span(int from, int to, logic p, logic r, string req);
        for (int i = from; i <= to; i++) expect_at(i, p, r, req);
    endtask

    // Scoreboard monitor: samples 2 ns after each rising edge
    always begin
        @(posedge clk);
        #2;
        for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i].at <= cyc) begin
                checks++;
                if (q[i].at < cyc || pwr_en !== q[i].pwr || sys_rst_n !== q[i].rstn) begin
                    errors++;
                    $display("FAIL %s cycle %0d: pwr_en=%b sys_rst_n=%b expected pwr_en=%b sys_rst_n=%b",
                             q[i].req, q[i].at, pwr_en, sys_rst_n, q[i].pwr, q[i].rstn);
                end
                q.delete(i);
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_cyc(int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic write_reg(logic [1:0] sel, logic [15:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic report;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not complete, cycle %0d expected end", cyc);
            report();
            $finish;
        end
    end

    initial begin
        int n;
        int m;
        tick(3);
        rst_n = 1'b1;
        n = cyc;
        expect_span(n + 1, n + 2, 1'b1, 1'b1, "R1");
        write_reg(2'd1, 16'h0020);              // filter T = 32
        write_reg(2'd2, 16'h0040);              // hold H = 64

        // R8: pin in run state does nothing
        n = cyc;
        expect_span(n + 1, n + 40, 1'b1, 1'b1, "R8");
        wake_pin = 1'b1;
        tick(40);
        wake_pin = 1'b0;
        tick(5);

        // R2: command with bit0 = 0 ignored
        n = cyc;
        expect_span(n + 1, n + 5, 1'b1, 1'b1, "R2");
        write_reg(2'd0, 16'h0002);
        tick(5);

        // R2: hibernate entry
        n = cyc;
        expect_span(n + 1, n + 4, 1'b0, 1'b1, "R2");
        write_reg(2'd0, 16'h0001);
        tick(5);

        // R5: pulse of T+1 edges is rejected
        n = cyc;
        expect_span(n + 1, n + 45, 1'b0, 1'b1, "R5");
        wake_pin = 1'b1;
        tick(33);
        wake_pin = 1'b0;
        wait_cyc(n + 46);

        // R4, R3, R5: full retry after clear, R7 hold length
        n = cyc;
        m = n + 36;
        expect_at(n + 35, 1'b0, 1'b1, "R4");
        expect_at(m, 1'b1, 1'b0, "R4");
        expect_at(m + 64, 1'b1, 1'b0, "R7");
        expect_at(m + 65, 1'b1, 1'b1, "R7");
        expect_at(m + 10, 1'b1, 1'b0, "R8");
        expect_span(m + 66, m + 75, 1'b1, 1'b1, "R8");
        wake_pin = 1'b1;
        wait_cyc(m + 5);
        write_reg(2'd0, 16'h0001);              // ignored during hold
        wait_cyc(m + 76);
        wake_pin = 1'b0;
        tick(3);

        // R4 boundary: exactly T+2 edges accepted
        n = cyc;
        expect_at(n + 1, 1'b0, 1'b1, "R2");
        write_reg(2'd0, 16'h0001);
        tick(3);
        n = cyc;
        expect_at(n + 35, 1'b0, 1'b1, "R4");
        expect_at(n + 36, 1'b1, 1'b0, "R4");
        wake_pin = 1'b1;
        tick(34);
        wake_pin = 1'b0;
        wait_cyc(n + 36 + 70);

        // R6, R7: low bits ignored (filter 0x3F -> 32, hold 0x1F -> 0)
        write_reg(2'd1, 16'h003F);
        write_reg(2'd2, 16'h001F);
        write_reg(2'd0, 16'h0001);
        tick(2);
        n = cyc;
        expect_at(n + 35, 1'b0, 1'b1, "R6");
        expect_at(n + 36, 1'b1, 1'b0, "R6");
        expect_at(n + 37, 1'b1, 1'b1, "R7");
        wake_pin = 1'b1;
        wait_cyc(n + 40);
        wake_pin = 1'b0;
        tick(3);

        // R6: filter 0x1F -> T = 0
        write_reg(2'd1, 16'h001F);
        write_reg(2'd0, 16'h0001);
        tick(2);
        n = cyc;
        expect_at(n + 3, 1'b0, 1'b1, "R6");
        expect_at(n + 4, 1'b1, 1'b0, "R6");
        expect_at(n + 5, 1'b1, 1'b1, "R7");
        wake_pin = 1'b1;
        wait_cyc(n + 8);
        wake_pin = 1'b0;

        while (q.size() != 0) tick(1);
        tick(2);
        done = 1;
        report();
        $finish;
    end
endmodule